// File: doc/BRIEF.md
# Receive Timestamp Capture Bank

This block sits beside a receive parser and keeps the precise clock time of incoming precision-time-protocol event frames until software collects it. The parser reduces each frame to a few strobes: a valid pulse, an event-message indication, the message type, and flags for version-1 encoding, raw layer-2 carriage and UDP carriage. When a frame passes the configured filter, the block copies the running 64-bit nanosecond clock into one of four storage slots. It reports the chosen slot number with the frame, so the descriptor logic can carry that number to software.

Software sees a busy bitmap with one bit per slot. It fetches a slot as two 32-bit words. Fetching the lower word leaves the slot untouched. Fetching the upper word hands the slot back for reuse. The filter is set by a global enable, a version select, a UDP recognition enable and a per-message-type mask. When every slot is occupied, a matching frame is marked as not timestamped and the stored values are left alone.

Top module: `rxts_latch_bank`

## Requirements
- R1: After reset the busy bitmap `ts_status` is 0, `frm_ts_taken` and `frm_ts_missed` are 0, and `rd_data` is 0.
- R2: A matching frame presented with `frm_valid` at a clock edge stores the `time_ns` value seen at that edge into the lowest-numbered free slot. In the next cycle `frm_ts_taken` is 1 for one cycle and `frm_ts_slot` gives that slot number.
- R3: Bit i of `ts_status` is 1 exactly while slot i holds a value not yet released. It is set in the cycle after the capture.
- R4: When all slots are busy, a matching frame gives `frm_ts_missed` = 1 and `frm_ts_taken` = 0 in the next cycle. Neither the bitmap nor any stored value changes.
- R5: A read with `rd_en` for slot `rd_slot` returns the stored bits [63:32] when `rd_hi` = 1, or bits [31:0] when `rd_hi` = 0. The data appears on `rd_data` in the next cycle and is held until the next read.
- R6: An upper-word read clears the slot's `ts_status` bit in the next cycle. A lower-word read leaves the bitmap unchanged.
- R7: With `cfg_ver` = 0 (version-1 mode), a frame matches only if `frm_is_v1`, `frm_udp` and `cfg_udp_en` are all 1. With `cfg_udp_en` = 0 no frame is stamped.
- R8: With `cfg_ver` = 1 (version-2 mode), a frame matches only if `frm_is_v1` = 0 and either `frm_l2` = 1, or `frm_udp` = 1 with `cfg_udp_en` = 1.
- R9: A capture also requires `cfg_enable` = 1, `frm_event` = 1, and bit `frm_msg_type` of `cfg_msg_mask` = 1. Otherwise the frame is neither taken nor missed.
- R10: A slot released by an upper-word read in the same cycle as a matching frame is not free for that frame. It becomes available from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_ns | input | 64 | Running clock value in nanoseconds |
| cfg_enable | input | 1 | Global timestamp enable |
| cfg_ver | input | 1 | 0 = version-1 filtering, 1 = version-2 filtering |
| cfg_udp_en | input | 1 | Recognise UDP-carried frames |
| cfg_msg_mask | input | 16 | One enable bit per message type |
| frm_valid | input | 1 | Frame strobe, one cycle per frame |
| frm_event | input | 1 | Frame is an event message |
| frm_msg_type | input | 4 | Message type field of the frame |
| frm_is_v1 | input | 1 | Frame uses version-1 encoding |
| frm_l2 | input | 1 | Frame carried directly over Ethernet |
| frm_udp | input | 1 | Frame carried over UDP |
| frm_ts_taken | output | 1 | Previous frame was timestamped |
| frm_ts_missed | output | 1 | Previous frame matched but no slot was free |
| frm_ts_slot | output | 2 | Slot used by the previous frame |
| ts_status | output | 4 | Busy bitmap, one bit per slot |
| rd_en | input | 1 | Read request |
| rd_slot | input | 2 | Slot to read |
| rd_hi | input | 1 | 1 = upper word (releases slot), 0 = lower word |
| rd_data | output | 32 | Read data, one cycle after the request |

## Verification
A bitmap bit stuck set loses that slot for good. The next frame that should have landed there goes to a higher slot or is reported missed. A bit that clears too early lets the following capture overwrite a value that was never read, so the next upper-word read returns a different time. An allocation error shows on `frm_ts_slot` in the cycle after the frame. A storage or word-select error shows on `rd_data` one cycle after the read. The full sweep over the transport and version inputs exposes a filter error on the first wrongly classified frame.

// File: rtl/rxts_pkg.sv
package rxts_pkg;

  typedef enum logic {
    PTP_VER1 = 1'b0,
    PTP_VER2 = 1'b1
  } ptp_ver_e;

  // Transport/version acceptance rule.
  function automatic logic ptp_transport_ok(ptp_ver_e ver, logic udp_en,
                                            logic is_v1, logic is_l2, logic is_udp);
    if (ver == PTP_VER1) return is_v1 & is_udp & udp_en;
    return ~is_v1 & (is_l2 | (is_udp & udp_en));
  endfunction

endpackage

// File: rtl/rxts_filter.sv
module rxts_filter
  import rxts_pkg::*;
#(
  parameter int MSG_W = 4
) (
  input  logic                enable,
  input  logic                ver,
  input  logic                udp_en,
  input  logic [(1<<MSG_W)-1:0] msg_mask,
  input  logic                valid,
  input  logic                is_event,
  input  logic [MSG_W-1:0]    msg_type,
  input  logic                is_v1,
  input  logic                is_l2,
  input  logic                is_udp,
  output logic                hit
);
  logic transport_ok;
  always_comb begin
    transport_ok = ptp_transport_ok(ptp_ver_e'(ver), udp_en, is_v1, is_l2, is_udp);
    hit = enable & valid & is_event & msg_mask[msg_type] & transport_ok;
  end
endmodule

// File: rtl/rxts_alloc.sv
module rxts_alloc #(
  parameter int N = 4,
  localparam int SLOT_W = $clog2(N)
) (
  input  logic [N-1:0]      busy,
  output logic [N-1:0]      grant,
  output logic [SLOT_W-1:0] grant_idx,
  output logic              none_free
);
  // Walk from the top down so the lowest free slot wins.
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    none_free = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        grant_idx = SLOT_W'(i);
        none_free = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxts_slot.sv
module rxts_slot #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            release_i,
  input  logic [TS_W-1:0] stamp_in,
  output logic [TS_W-1:0] stamp_q,
  output logic            busy_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      if (load) begin
        stamp_q <= stamp_in;
        busy_q  <= 1'b1;
      end else if (release_i) begin
        busy_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxts_latch_bank.sv
module rxts_latch_bank #(
  parameter int N      = 4,
  parameter int WORD_W = 32,
  parameter int MSG_W  = 4,
  localparam int TS_W   = 2 * WORD_W,
  localparam int SLOT_W = $clog2(N),
  localparam int MASK_W = 1 << MSG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   time_ns,
  input  logic              cfg_enable,
  input  logic              cfg_ver,
  input  logic              cfg_udp_en,
  input  logic [MASK_W-1:0] cfg_msg_mask,
  input  logic              frm_valid,
  input  logic              frm_event,
  input  logic [MSG_W-1:0]  frm_msg_type,
  input  logic              frm_is_v1,
  input  logic              frm_l2,
  input  logic              frm_udp,
  output logic              frm_ts_taken,
  output logic              frm_ts_missed,
  output logic [SLOT_W-1:0] frm_ts_slot,
  output logic [N-1:0]      ts_status,
  input  logic              rd_en,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic              rd_hi,
  output logic [WORD_W-1:0] rd_data
);
  logic              hit_w;
  logic [N-1:0]      busy_w, grant_w, load_w, release_w;
  logic [SLOT_W-1:0] grant_idx_w;
  logic              none_free_w;
  logic [TS_W-1:0]   stamp_w [N];

  rxts_filter #(.MSG_W(MSG_W)) i_filter (
    .enable(cfg_enable), .ver(cfg_ver), .udp_en(cfg_udp_en), .msg_mask(cfg_msg_mask),
    .valid(frm_valid), .is_event(frm_event), .msg_type(frm_msg_type),
    .is_v1(frm_is_v1), .is_l2(frm_l2), .is_udp(frm_udp), .hit(hit_w)
  );

  rxts_alloc #(.N(N)) i_alloc (
    .busy(busy_w), .grant(grant_w), .grant_idx(grant_idx_w), .none_free(none_free_w)
  );

  always_comb begin
    load_w    = hit_w ? grant_w : '0;
    release_w = '0;
    for (int i = 0; i < N; i++)
      if (rd_en && rd_hi && (rd_slot == SLOT_W'(i))) release_w[i] = 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    rxts_slot #(.TS_W(TS_W)) i_slot (
      .clk(clk), .rst_n(rst_n), .load(load_w[g]), .release_i(release_w[g]),
      .stamp_in(time_ns), .stamp_q(stamp_w[g]), .busy_q(busy_w[g])
    );
  end

  assign ts_status = busy_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_ts_taken  <= 1'b0;
      frm_ts_missed <= 1'b0;
      frm_ts_slot   <= '0;
      rd_data       <= '0;
    end else begin
      frm_ts_taken  <= hit_w & ~none_free_w;
      frm_ts_missed <= hit_w & none_free_w;
      if (hit_w && !none_free_w) frm_ts_slot <= grant_idx_w;
      if (rd_en) rd_data <= rd_hi ? stamp_w[rd_slot][TS_W-1:WORD_W]
                                  : stamp_w[rd_slot][WORD_W-1:0];
    end
  end
endmodule

// File: rtl/rxts_latch_bank_chk.sv
module rxts_latch_bank_chk #(
  parameter int N      = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              frm_ts_taken,
  input logic              frm_ts_missed,
  input logic [N-1:0]      ts_status,
  input logic              rd_en,
  input logic              rd_hi,
  input logic [SLOT_W-1:0] rd_slot,
  input logic [N-1:0]      load_w,
  input logic [N-1:0]      busy_w
);
  // R2
  load_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w & busy_w) == '0);

  // R2
  single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_w));

  // R4
  miss_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ts_missed |-> $past(&ts_status));

  // R6
  hi_read_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_hi) |=> !ts_status[$past(rd_slot)]);

  // R6
  lo_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hi && ts_status[rd_slot]) |=> ts_status[$past(rd_slot)]);

  // R9
  disabled_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!frm_ts_taken && !frm_ts_missed));

  // R2
  taken_xor_missed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_ts_taken && frm_ts_missed));
endmodule

bind rxts_latch_bank rxts_latch_bank_chk #(.N(N), .SLOT_W(SLOT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .frm_ts_taken(frm_ts_taken),
  .frm_ts_missed(frm_ts_missed), .ts_status(ts_status), .rd_en(rd_en), .rd_hi(rd_hi),
  .rd_slot(rd_slot), .load_w(load_w), .busy_w(busy_w)
);

// File: tb/test_rxts_latch_bank.sv
`timescale 1ns/1ps
module test_rxts_latch_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_ns = '0;
  logic        cfg_enable = 1'b1, cfg_ver = 1'b0, cfg_udp_en = 1'b1;
  logic [15:0] cfg_msg_mask = 16'hFFFF;
  logic        frm_valid = 1'b0, frm_event = 1'b0, frm_is_v1 = 1'b0, frm_l2 = 1'b0, frm_udp = 1'b0;
  logic [3:0]  frm_msg_type = '0;
  logic        frm_ts_taken, frm_ts_missed;
  logic [1:0]  frm_ts_slot;
  logic [3:0]  ts_status;
  logic        rd_en = 1'b0, rd_hi = 1'b0;
  logic [1:0]  rd_slot = '0;
  logic [31:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxts_latch_bank i_rxts_latch_bank (
    .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .cfg_enable(cfg_enable), .cfg_ver(cfg_ver),
    .cfg_udp_en(cfg_udp_en), .cfg_msg_mask(cfg_msg_mask), .frm_valid(frm_valid),
    .frm_event(frm_event), .frm_msg_type(frm_msg_type), .frm_is_v1(frm_is_v1),
    .frm_l2(frm_l2), .frm_udp(frm_udp), .frm_ts_taken(frm_ts_taken),
    .frm_ts_missed(frm_ts_missed), .frm_ts_slot(frm_ts_slot), .ts_status(ts_status),
    .rd_en(rd_en), .rd_slot(rd_slot), .rd_hi(rd_hi), .rd_data(rd_data)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] stamp_of(int n);
    return {32'hC0DE_0000 | 32'(n), 32'h1234_0000 | 32'(n * 3)};
  endfunction

  task automatic send(logic ev, logic [3:0] mt, logic v1, logic l2, logic udp,
                      logic [63:0] t, output logic tk, output logic ms, output logic [1:0] sl);
    @(negedge clk);
    frm_valid = 1'b1; frm_event = ev; frm_msg_type = mt;
    frm_is_v1 = v1; frm_l2 = l2; frm_udp = udp; time_ns = t;
    @(negedge clk);
    frm_valid = 1'b0;
    tk = frm_ts_taken; ms = frm_ts_missed; sl = frm_ts_slot;
  endtask

  task automatic rd(logic [1:0] s, logic hi, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_slot = s; rd_hi = hi;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic tk, ms;
    logic [1:0] sl;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "status", 64'(ts_status), 0);
    chk("R1", "taken", 64'(frm_ts_taken), 0);
    chk("R1", "missed", 64'(frm_ts_missed), 0);
    chk("R1", "rd_data", 64'(rd_data), 0);

    // R7 R8: sweep of version, UDP enable and transport flags
    for (int c = 0; c < 32; c++) begin
      logic ver, uen, v1, l2, udp, exp;
      {ver, uen, v1, l2, udp} = 5'(c);
      cfg_ver = ver; cfg_udp_en = uen;
      exp = ver ? (!v1 && (l2 || (udp && uen))) : (v1 && udp && uen);
      send(1'b1, 4'd0, v1, l2, udp, stamp_of(c), tk, ms, sl);
      chk(ver ? "R8" : "R7", "taken", 64'(tk), 64'(exp));
      chk(ver ? "R8" : "R7", "missed", 64'(ms), 0);
      if (tk) begin
        chk("R2", "slot", 64'(sl), 0);
        rd(2'd0, 1'b1, d);
        chk("R5", "hi word", 64'(d), 64'(stamp_of(c) >> 32));
        chk("R6", "status after hi", 64'(ts_status), 0);
      end
    end

    // R9: message mask, event strobe and enable
    cfg_ver = 1'b1; cfg_udp_en = 1'b1; cfg_msg_mask = 16'hA5C3;
    for (int m = 0; m < 16; m++) begin
      logic exp;
      exp = (16'hA5C3 >> m) & 1;
      send(1'b1, 4'(m), 1'b0, 1'b1, 1'b0, stamp_of(100 + m), tk, ms, sl);
      chk("R9", "mask taken", 64'(tk), 64'(exp));
      if (tk) rd(2'd0, 1'b1, d);
    end
    cfg_msg_mask = 16'hFFFF;
    send(1'b0, 4'd0, 1'b0, 1'b1, 1'b0, stamp_of(200), tk, ms, sl);
    chk("R9", "no event", 64'({tk, ms}), 0);
    cfg_enable = 1'b0;
    send(1'b1, 4'd0, 1'b0, 1'b1, 1'b0, stamp_of(201), tk, ms, sl);
    chk("R9", "disabled", 64'({tk, ms}), 0);
    chk("R9", "status", 64'(ts_status), 0);
    cfg_enable = 1'b1;

    // R2 R3: fill all slots in order
    for (int k = 0; k < 4; k++) begin
      send(1'b1, 4'd1, 1'b0, 1'b1, 1'b0, stamp_of(300 + k), tk, ms, sl);
      chk("R2", "fill taken", 64'(tk), 1);
      chk("R2", "fill slot", 64'(sl), 64'(k));
      chk("R3", "fill status", 64'(ts_status), 64'((1 << (k + 1)) - 1));
    end
    // R4: full bank
    send(1'b1, 4'd1, 1'b0, 1'b1, 1'b0, stamp_of(400), tk, ms, sl);
    chk("R4", "full taken", 64'(tk), 0);
    chk("R4", "full missed", 64'(ms), 1);
    chk("R4", "full status", 64'(ts_status), 64'hF);
    // R5 R6: low reads keep the slot
    for (int k = 0; k < 4; k++) begin
      rd(2'(k), 1'b0, d);
      chk("R5", "lo word", 64'(d), 64'(stamp_of(300 + k) & 64'hFFFF_FFFF));
    end
    chk("R6", "status after lo reads", 64'(ts_status), 64'hF);
    rd(2'd2, 1'b1, d);
    chk("R5", "hi word slot2", 64'(d), 64'(stamp_of(302) >> 32));
    chk("R6", "slot2 freed", 64'(ts_status), 64'hB);
    send(1'b1, 4'd1, 1'b0, 1'b1, 1'b0, stamp_of(500), tk, ms, sl);
    chk("R2", "reuse slot", 64'(sl), 2);
    chk("R2", "reuse taken", 64'(tk), 1);

    // R10: release and frame in the same cycle
    @(negedge clk);
    rd_en = 1'b1; rd_slot = 2'd1; rd_hi = 1'b1;
    frm_valid = 1'b1; frm_event = 1'b1; frm_msg_type = 4'd1;
    frm_is_v1 = 1'b0; frm_l2 = 1'b1; frm_udp = 1'b0; time_ns = stamp_of(600);
    @(negedge clk);
    rd_en = 1'b0; frm_valid = 1'b0;
    chk("R10", "missed", 64'(frm_ts_missed), 1);
    chk("R10", "taken", 64'(frm_ts_taken), 0);
    chk("R10", "status", 64'(ts_status), 64'hD);
    chk("R10", "hi slot1", 64'(rd_data), 64'(stamp_of(301) >> 32));
    rd(2'd2, 1'b0, d);
    chk("R2", "slot2 lo", 64'(d), 64'(stamp_of(500) & 64'hFFFF_FFFF));
    rd(2'd0, 1'b1, d);
    chk("R4", "slot0 intact", 64'(d), 64'(stamp_of(300) >> 32));
    send(1'b1, 4'd1, 1'b0, 1'b1, 1'b0, stamp_of(700), tk, ms, sl);
    chk("R10", "lowest after frees", 64'(sl), 0);

    done = 1;
    finish_run();
  end
endmodule